// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Controller

This block sits next to an instruction fetch unit and lets counted loops repeat with no branch instruction in the loop body and no lost fetch slot. A loop-setup command records three things: the iteration count, the absolute address of the last loop instruction, and the fetch address present in the setup cycle, which becomes the loop start. Setups go onto a small stack, so loops can nest.

On every valid fetch the controller compares the fetch address with a trigger address held in the top stack entry. The trigger is the loop end minus a fixed pipeline length, so the redirect can be issued early enough for the first body instruction to follow the last one without a bubble. On a match the fetch unit is sent back to the loop start and the count drops by one. On the final pass no redirect is issued, fetch falls through, and the entry is popped at that same clock edge. An entry can be marked endless, so it never counts down. A clear command turns the current loop into one whose next end is its last. An explicit pop command abandons the top loop.

Top module: `hwloop_ctl`

## Requirements
- R1: After reset the stack is empty (`depth` = 0), `redirect` is 0 and both error flags are 0.
- R2: A cycle with `init_valid` pushes an entry whose start is `fetch_addr` of that cycle, whose trigger is `init_end - PIPE_LEN` taken modulo 2^AW, with `init_count` and `init_endless`; `depth` rises by one at that clock edge.
- R3: `redirect` is 1 in the same cycle exactly when `fetch_valid` is 1, the stack is not empty, `fetch_addr` equals the top trigger, and the top entry is endless or has a count above 1. `redirect_addr` then equals the top start; otherwise both outputs are 0.
- R4: Each redirect of a non-endless entry lowers its count by one. A loop set up with count N >= 1 therefore redirects N-1 times. A count of 0 or 1 exits at the first match.
- R5: A match that does not redirect pops the top entry at that clock edge, and the next fetch is compared against the enclosing entry.
- R6: Only the top entry is compared. A fetch address equal to a lower entry's trigger has no effect.
- R7: An endless entry redirects on every match and is never counted down.
- R8: `clear_cnt` sets the top count to 1 and clears its endless mark, so the next match exits. It has no effect on an empty stack or when the top entry is popped in the same cycle.
- R9: `loop_pop` removes the top entry unless a match already popped it in that cycle. On an empty stack it is ignored and sets the sticky `underflow_err`.
- R10: Pops are applied before the push in the same cycle. A push that finds `DEPTH` entries after those pops is ignored and sets the sticky `overflow_err`.
- R11: `depth` always equals the number of stored entries and never exceeds `DEPTH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_valid | input | 1 | A fetch occurs this cycle |
| fetch_addr | input | AW (16) | Current fetch address |
| init_valid | input | 1 | Loop-setup command |
| init_count | input | CW (16) | Iteration count for the new loop |
| init_end | input | AW (16) | Address of the last loop instruction |
| init_endless | input | 1 | New loop never counts down |
| clear_cnt | input | 1 | Force exit at the next loop end |
| loop_pop | input | 1 | Abandon the top loop |
| redirect | output | 1 | Load `redirect_addr` into the fetch pointer |
| redirect_addr | output | AW (16) | Loop start address for the redirect |
| depth | output | 3 | Number of stored loop entries |
| overflow_err | output | 1 | Sticky: push on a full stack |
| underflow_err | output | 1 | Sticky: pop on an empty stack |

## Verification
`redirect` and `redirect_addr` are combinational in the fetch cycle, while `depth`, the count change and both error flags take effect at the next rising edge. The bench drives every input at the falling edge and samples the redirect outputs 1 ns later, in the same cycle. It then samples `depth` and the flags 1 ns after the following rising edge, where its own stack model has applied that cycle's pops, count change, clear and push in the order the requirements give.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;

    // Outcome of comparing the fetch address with the top loop entry
    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,  // no match (or no fetch / empty stack)
        ACT_REPEAT = 2'd1,  // match, counted loop goes round again
        ACT_STAY   = 2'd2,  // match, endless loop goes round again
        ACT_EXIT   = 2'd3   // match on the final pass, fall through
    } hit_act_e;

    function automatic logic act_redirects(hit_act_e a);
        return (a == ACT_REPEAT) || (a == ACT_STAY);
    endfunction

endpackage

// File: rtl/hwloop_match.sv
module hwloop_match
    import hwloop_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          fetch_valid,
    input  logic [AW-1:0] fetch_addr,
    input  logic          stack_empty,
    input  logic [AW-1:0] top_start,
    input  logic [AW-1:0] top_trig,
    input  logic [CW-1:0] top_cnt,
    input  logic          top_endless,
    output hit_act_e      act,
    output logic          redirect,
    output logic [AW-1:0] redirect_addr
);

    logic hit;

    always_comb begin
        hit = fetch_valid && !stack_empty && (fetch_addr == top_trig);
        act = ACT_NONE;
        if (hit) begin
            if (top_endless)
                act = ACT_STAY;
            else if (top_cnt > CW'(1))
                act = ACT_REPEAT;
            else
                act = ACT_EXIT;
        end
        redirect      = act_redirects(act);
        redirect_addr = redirect ? top_start : '0;
    end

endmodule

// File: rtl/hwloop_stack.sv
module hwloop_stack
    import hwloop_pkg::*;
#(
    parameter int AW       = 16,
    parameter int CW       = 16,
    parameter int DEPTH    = 4,
    parameter int PIPE_LEN = 2,
    parameter int SPW      = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  hit_act_e      act_i,
    input  logic          pop_i,
    input  logic          clr_i,
    input  logic          push_i,
    input  logic [AW-1:0] push_start_i,
    input  logic [AW-1:0] push_end_i,
    input  logic [CW-1:0] push_cnt_i,
    input  logic          push_endless_i,
    output logic [AW-1:0] top_start_o,
    output logic [AW-1:0] top_trig_o,
    output logic [CW-1:0] top_cnt_o,
    output logic          top_endless_o,
    output logic          empty_o,
    output logic [SPW-1:0] depth_o,
    output logic          ovf_o,
    output logic          unf_o
);

    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [AW-1:0] start;
        logic [AW-1:0] trig;
        logic [CW-1:0] cnt;
        logic          endless;
    } entry_t;

    typedef struct packed {
        entry_t [DEPTH-1:0] stk;
        logic [SPW-1:0]     sp;
        logic               ovf;
        logic               unf;
    } state_t;

    state_t q, d;
    logic [IW-1:0] tix;
    logic [IW-1:0] pix;
    logic          popped;
    entry_t        new_e;
    entry_t        top_e;

    always_comb begin
        d      = q;
        popped = 1'b0;
        tix    = (q.sp == '0) ? '0 : IW'(q.sp - 1'b1);
        top_e  = q.stk[tix];

        new_e.start   = push_start_i;
        new_e.trig    = push_end_i - AW'(PIPE_LEN);
        new_e.cnt     = push_cnt_i;
        new_e.endless = push_endless_i;

        // 1) outcome of this cycle's fetch compare
        if (act_i == ACT_REPEAT)
            d.stk[tix].cnt = top_e.cnt - 1'b1;
        if (act_i == ACT_EXIT) begin
            d.sp   = q.sp - 1'b1;
            popped = 1'b1;
        end

        // 2) explicit pop, unless the top already left
        if (pop_i && !popped) begin
            if (q.sp == '0) begin
                d.unf = 1'b1;
            end else begin
                d.sp   = q.sp - 1'b1;
                popped = 1'b1;
            end
        end

        // 3) clear applies to a top entry that is still present
        if (clr_i && !popped && (q.sp != '0)) begin
            d.stk[tix].cnt     = CW'(1);
            d.stk[tix].endless = 1'b0;
        end

        // 4) push after all pops
        pix = IW'(d.sp);
        if (push_i) begin
            if (d.sp == SPW'(DEPTH)) begin
                d.ovf = 1'b1;
            end else begin
                d.stk[pix] = new_e;
                d.sp       = d.sp + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

    assign top_start_o   = top_e.start;
    assign top_trig_o    = top_e.trig;
    assign top_cnt_o     = top_e.cnt;
    assign top_endless_o = top_e.endless;
    assign empty_o       = (q.sp == '0);
    assign depth_o       = q.sp;
    assign ovf_o         = q.ovf;
    assign unf_o         = q.unf;

endmodule

// File: rtl/hwloop_ctl.sv
module hwloop_ctl
    import hwloop_pkg::*;
#(
    parameter int AW       = 16,
    parameter int CW       = 16,
    parameter int DEPTH    = 4,
    parameter int PIPE_LEN = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         fetch_valid,
    input  logic [AW-1:0]                fetch_addr,
    input  logic                         init_valid,
    input  logic [CW-1:0]                init_count,
    input  logic [AW-1:0]                init_end,
    input  logic                         init_endless,
    input  logic                         clear_cnt,
    input  logic                         loop_pop,
    output logic                         redirect,
    output logic [AW-1:0]                redirect_addr,
    output logic [$clog2(DEPTH+1)-1:0]   depth,
    output logic                         overflow_err,
    output logic                         underflow_err
);

    localparam int SPW = $clog2(DEPTH + 1);

    hit_act_e      act_w;
    logic          empty_w;
    logic [AW-1:0] top_start_w;
    logic [AW-1:0] top_trig_w;
    logic [CW-1:0] top_cnt_w;
    logic          top_endless_w;

    hwloop_match #(
        .AW (AW),
        .CW (CW)
    ) u_match (
        .fetch_valid   (fetch_valid),
        .fetch_addr    (fetch_addr),
        .stack_empty   (empty_w),
        .top_start     (top_start_w),
        .top_trig      (top_trig_w),
        .top_cnt       (top_cnt_w),
        .top_endless   (top_endless_w),
        .act           (act_w),
        .redirect      (redirect),
        .redirect_addr (redirect_addr)
    );

    hwloop_stack #(
        .AW       (AW),
        .CW       (CW),
        .DEPTH    (DEPTH),
        .PIPE_LEN (PIPE_LEN),
        .SPW      (SPW)
    ) u_stack (
        .clk            (clk),
        .rst_n          (rst_n),
        .act_i          (act_w),
        .pop_i          (loop_pop),
        .clr_i          (clear_cnt),
        .push_i         (init_valid),
        .push_start_i   (fetch_addr),
        .push_end_i     (init_end),
        .push_cnt_i     (init_count),
        .push_endless_i (init_endless),
        .top_start_o    (top_start_w),
        .top_trig_o     (top_trig_w),
        .top_cnt_o      (top_cnt_w),
        .top_endless_o  (top_endless_w),
        .empty_o        (empty_w),
        .depth_o        (depth),
        .ovf_o          (overflow_err),
        .unf_o          (underflow_err)
    );

endmodule

// File: rtl/hwloop_ctl_chk.sv
module hwloop_ctl_chk
    import hwloop_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int SPW   = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           fetch_valid,
    input logic           init_valid,
    input logic           loop_pop,
    input logic           redirect,
    input logic           overflow_err,
    input logic           underflow_err,
    input logic [SPW-1:0] depth,
    input hit_act_e       act
);

    // R11: never more entries than the stack holds
    a_r11_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= SPW'(DEPTH));

    // R3: a redirect needs a fetch and a stored loop
    a_r3_redirect_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> (fetch_valid && depth != '0));

    // R9: underflow flag is sticky
    a_r9_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_err |=> underflow_err);

    // R10: overflow flag is sticky
    a_r10_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_err |=> overflow_err);

    // R5: a final-pass match removes one entry when nothing is pushed
    a_r5_exit_pops: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_EXIT && !init_valid) |=> depth == SPW'($past(depth) - 1'b1));

    // R4: a repeating match leaves the stack size alone
    a_r4_repeat_keeps_depth: assert property (@(posedge clk) disable iff (!rst_n)
        ((act == ACT_REPEAT || act == ACT_STAY) && !init_valid && !loop_pop) |=> $stable(depth));

    // R2: a push with room grows the stack by one
    a_r2_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (init_valid && act == ACT_NONE && !loop_pop && depth < SPW'(DEPTH))
        |=> depth == SPW'($past(depth) + 1'b1));

    // R10: a push onto a full stack raises the overflow flag
    a_r10_full_push_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (init_valid && act == ACT_NONE && !loop_pop && depth == SPW'(DEPTH)) |=> overflow_err);

endmodule

bind hwloop_ctl hwloop_ctl_chk #(
    .DEPTH (DEPTH),
    .SPW   (SPW)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fetch_valid   (fetch_valid),
    .init_valid    (init_valid),
    .loop_pop      (loop_pop),
    .redirect      (redirect),
    .overflow_err  (overflow_err),
    .underflow_err (underflow_err),
    .depth         (depth),
    .act           (act_w)
);

// File: tb/hwloop_ctl_test.sv
`timescale 1ns/1ps
module hwloop_ctl_test;

    localparam int AW    = 16;
    localparam int CW    = 16;
    localparam int DEPTH = 4;
    localparam int PL    = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fetch_valid = 1'b0;
    logic [AW-1:0] fetch_addr = '0;
    logic          init_valid = 1'b0;
    logic [CW-1:0] init_count = '0;
    logic [AW-1:0] init_end = '0;
    logic          init_endless = 1'b0;
    logic          clear_cnt = 1'b0;
    logic          loop_pop = 1'b0;
    logic          redirect;
    logic [AW-1:0] redirect_addr;
    logic [2:0]    depth;
    logic          overflow_err;
    logic          underflow_err;

    always #10 clk = ~clk;   // 50 MHz

    hwloop_ctl #(.AW(AW), .CW(CW), .DEPTH(DEPTH), .PIPE_LEN(PL)) uut (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .init_valid(init_valid), .init_count(init_count), .init_end(init_end),
        .init_endless(init_endless), .clear_cnt(clear_cnt), .loop_pop(loop_pop),
        .redirect(redirect), .redirect_addr(redirect_addr), .depth(depth),
        .overflow_err(overflow_err), .underflow_err(underflow_err)
    );

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // bench's own loop stack model
    logic [AW-1:0] m_start [DEPTH];
    logic [AW-1:0] m_trig  [DEPTH];
    logic [CW-1:0] m_cnt   [DEPTH];
    bit            m_endl  [DEPTH];
    int            m_sp = 0;
    bit            m_ovf = 0;
    bit            m_unf = 0;

    logic          obs_red;
    logic [AW-1:0] obs_addr;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_sp = 0; m_ovf = 0; m_unf = 0;
    endtask

    // One fetch cycle: drive at falling edge, check same-cycle outputs,
    // advance the model, check registered outputs after the rising edge.
    task automatic step(input bit fv, input logic [AW-1:0] fa, input bit ini,
                        input logic [CW-1:0] cnt, input logic [AW-1:0] ea, input bit endl,
                        input bit clr, input bit pop);
        bit hit, exp_red, popped;
        logic [AW-1:0] exp_addr;
        int top;
        @(negedge clk);
        fetch_valid = fv; fetch_addr = fa; init_valid = ini; init_count = cnt;
        init_end = ea; init_endless = endl; clear_cnt = clr; loop_pop = pop;
        #1;
        top = (m_sp > 0) ? m_sp - 1 : 0;
        hit = fv && (m_sp > 0) && (fa == m_trig[top]);
        exp_red = hit && (m_endl[top] || m_cnt[top] > 1);
        exp_addr = exp_red ? m_start[top] : '0;
        obs_red = redirect; obs_addr = redirect_addr;
        chk("R3 redirect", {31'd0, redirect}, {31'd0, exp_red});
        chk("R3 redirect_addr", {16'd0, redirect_addr}, {16'd0, exp_addr});
        // model update in requirement order
        popped = 0;
        if (exp_red && !m_endl[top]) m_cnt[top] = m_cnt[top] - 1'b1;   // R4
        if (hit && !exp_red) begin m_sp--; popped = 1; end               // R5
        if (pop && !popped) begin                                         // R9
            if (m_sp == 0) m_unf = 1;
            else begin m_sp--; popped = 1; end
        end
        if (clr && !popped && m_sp > 0) begin                             // R8
            m_cnt[m_sp-1] = 1; m_endl[m_sp-1] = 0;
        end
        if (ini) begin                                                    // R2, R10
            if (m_sp == DEPTH) m_ovf = 1;
            else begin
                m_start[m_sp] = fa; m_trig[m_sp] = ea - AW'(PL);
                m_cnt[m_sp] = cnt; m_endl[m_sp] = endl; m_sp++;
            end
        end
        @(posedge clk); #1;
        chk("R11 depth", {29'd0, depth}, 32'(m_sp));
        chk("R10 overflow_err", {31'd0, overflow_err}, {31'd0, m_ovf});
        chk("R9 underflow_err", {31'd0, underflow_err}, {31'd0, m_unf});
    endtask

    task automatic fetch(input logic [AW-1:0] fa);
        step(1, fa, 0, '0, '0, 0, 0, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; fetch_valid = 1; fetch_addr = '0; init_valid = 0;
        clear_cnt = 0; loop_pop = 0;
        repeat (3) @(posedge clk);
        #1;
        model_reset();
        chk("R1 depth after reset", {29'd0, depth}, 32'd0);
        chk("R1 redirect after reset", {31'd0, redirect}, 32'd0);
        chk("R1 overflow after reset", {31'd0, overflow_err}, 32'd0);
        chk("R1 underflow after reset", {31'd0, underflow_err}, 32'd0);
        @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int nred;
        logic [AW-1:0] pc;
        void'($urandom(32'd20240611));
        do_reset();

        // R4: count 3, loop 10..13, trigger at 11 -> two redirects then exit
        step(1, 16'd10, 1, 16'd3, 16'd13, 0, 0, 0);
        chk("R2 push depth", {29'd0, depth}, 32'd1);
        pc = 16'd11; nred = 0;
        for (int i = 0; i < 8; i++) begin
            fetch(pc);
            if (obs_red) begin nred++; pc = obs_addr; end
            else pc = pc + 1'b1;
        end
        chk("R4 redirect count for N=3", 32'(nred), 32'd2);
        chk("R5 stack empty after exit", {29'd0, depth}, 32'd0);

        // R4: count 0 exits at first match
        step(1, 16'd50, 1, 16'd0, 16'd53, 0, 0, 0);
        fetch(16'd51);
        chk("R4 count 0 no redirect", {31'd0, obs_red}, 32'd0);
        chk("R4 count 0 popped", {29'd0, depth}, 32'd0);

        // R2: trigger wraps modulo 2^AW (end 1 - 2 = 0xFFFF)
        step(1, 16'd70, 1, 16'd2, 16'd1, 0, 0, 0);
        fetch(16'hFFFF);
        chk("R2 wrapped trigger redirect", {31'd0, obs_red}, 32'd1);
        chk("R2 start captured", {16'd0, obs_addr}, 32'd70);
        fetch(16'hFFFF);

        // R6 / R5: nesting, only the top entry is compared
        step(1, 16'd20, 1, 16'd2, 16'd30, 0, 0, 0);   // outer, trigger 28
        step(1, 16'd21, 1, 16'd1, 16'd24, 0, 0, 0);   // inner, trigger 22
        fetch(16'd28);
        chk("R6 lower trigger ignored", {31'd0, obs_red}, 32'd0);
        chk("R6 depth kept", {29'd0, depth}, 32'd2);
        fetch(16'd22);                                  // inner exits
        chk("R5 inner popped", {29'd0, depth}, 32'd1);
        fetch(16'd28);                                  // enclosing loop now compared
        chk("R5 enclosing redirect", {31'd0, obs_red}, 32'd1);
        chk("R5 enclosing start", {16'd0, obs_addr}, 32'd20);
        fetch(16'd28);

        // R7 / R8: endless loop then clear
        step(1, 16'd40, 1, 16'd0, 16'd43, 1, 0, 0);
        nred = 0;
        for (int i = 0; i < 5; i++) begin
            fetch(16'd41);
            if (obs_red) nred++;
        end
        chk("R7 endless redirects every match", 32'(nred), 32'd5);
        step(0, 16'd0, 0, '0, '0, 0, 1, 0);
        fetch(16'd41);
        chk("R8 cleared loop exits", {31'd0, obs_red}, 32'd0);
        chk("R8 cleared loop popped", {29'd0, depth}, 32'd0);
        step(0, 16'd0, 0, '0, '0, 0, 1, 0);
        chk("R8 clear on empty no effect", {29'd0, depth}, 32'd0);

        // R10: fifth push overflows
        for (int i = 0; i < 5; i++) step(0, 16'(100 + i), 1, 16'd5, 16'd200, 0, 0, 0);
        chk("R10 overflow set", {31'd0, overflow_err}, 32'd1);
        chk("R10 depth capped", {29'd0, depth}, 32'd4);
        // R9: pops down to empty, then one more
        for (int i = 0; i < 4; i++) step(0, '0, 0, '0, '0, 0, 0, 1);
        chk("R9 no underflow yet", {31'd0, underflow_err}, 32'd0);
        step(0, '0, 0, '0, '0, 0, 0, 1);
        chk("R9 underflow set", {31'd0, underflow_err}, 32'd1);
        chk("R9 empty pop keeps depth", {29'd0, depth}, 32'd0);

        // Random mix against the model (R2..R11)
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            automatic bit fv  = ($urandom % 10) < 8;
            automatic logic [AW-1:0] fa = AW'($urandom % 16);
            automatic bit ini = ($urandom % 10) == 0;
            automatic logic [CW-1:0] cn = CW'($urandom % 4);
            automatic logic [AW-1:0] ea = AW'($urandom % 16);
            automatic bit en  = ($urandom % 16) == 0;
            automatic bit cl  = ($urandom % 20) == 0;
            automatic bit pp  = ($urandom % 20) == 0;
            step(fv, fa, ini, cn, ea, en, cl, pp);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule